// File: doc/BRIEF.md
# DMA Channel Control and Status Register Bank

This block holds the software-visible state of one peripheral DMA channel. It has four 32-bit registers: a command/status word, a transfer address and two auxiliary words. Software reaches them through a simple word-wide register bus. Each bus request lasts one cycle and carries valid, write, a byte address and write data. Read data comes back one cycle after the request, marked by a one-cycle valid strobe. Only full-word accesses exist. Address bits [3:2] pick the register and all other address bits are ignored.

The command/status word combines several kinds of bit:

- It carries a fixed version code and a field that software cannot overwrite.
- A level request from the attached peripheral drives the interrupt-pending bit. This bit is gated with a software enable bit to form the interrupt output.
- A reset command bit fires a one-clock reset pulse to the peripheral.
- A drain command bit is cleared on store, and a write of all zeros is turned into a drain request.
- A channel-enable bit drives a DMA-enable level to the peripheral.
- Writing the address register sets a sticky "loaded" status bit.

The data-moving engine, FIFO contents and address translation live elsewhere.

Top module: `dma_chan_regs`

## Requirements
- R1: After reset, register 0 (command/status) reads 0xA0000000 and registers 1, 2 and 3 read 0. The interrupt, reset-pulse and DMA-enable outputs are low.
- R2: Address bits [3:2] select the register: 0 is command/status, 1 is address, 2 and 3 are auxiliary. Other address bits have no effect. A read request returns the selected register's value on `bus_rdata` one cycle later, with `bus_rvalid` high for exactly that cycle.
- R3: Bit 0 of register 0 (pending) takes the level of `periph_irq_req` sampled at each clock edge, so it follows the input with one cycle of delay. Software writes cannot change it.
- R4: `irq_out` is high exactly while bit 0 (pending) and bit 4 (interrupt enable) of register 0 are both set. Setting bit 4 while pending is set raises the output, and clearing bit 4 drops it.
- R5: On a write to register 0, bits inside 0x01FFFFF8 take the written value, after the drain rule of R7 has been applied.
- R6: A write to register 0 with bit 7 set makes `periph_rst_pulse` high for exactly the one cycle after the write. Bit 7 is stored as written.
- R7: When bit 7 of the written value is clear, bit 6 (drain) is stored as 0 if it was written as 1. When the whole written value is zero, bit 6 is stored as 1.
- R8: `periph_dma_en` equals bit 9 of register 0. It rises when a write turns bit 9 from 0 to 1 and falls when a write turns it from 1 to 0.
- R9: Bits inside 0xFE000007 keep their value across writes to register 0. The version bits 0xA0000000 always read as set.
- R10: A write to register 1 sets bit 26 (loaded) of register 0, and that bit stays set until reset. Registers 1, 2 and 3 store written values unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Register bus request strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address; bits [3:2] select the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid when bus_rvalid is high |
| bus_rvalid | output | 1 | Read data strobe, one cycle after a read request |
| periph_irq_req | input | 1 | Level interrupt request from the peripheral |
| irq_out | output | 1 | Gated interrupt output |
| periph_rst_pulse | output | 1 | One-cycle reset pulse to the peripheral |
| periph_dma_en | output | 1 | DMA-enable level to the peripheral |

## Verification
The assertions check the following on every cycle:

- The fixed and protected bits hold their values.
- The loaded bit is set and stays set after an address write.
- The reset pulse appears only after a control write with bit 7 set.
- The DMA-enable output changes only after a control write.
- Read strobes follow read requests.
- The interrupt output is never high unless the peripheral request was high on the previous cycle.

The bench's scenarios show the exact stored value of each control write. They cover the zero-write drain rule, the drain-clear rule and whether bit 7 overrides them. They show that raising and dropping the interrupt follows writes to bit 4 while pending stays set, and that upper address bits alias to the same registers.

// File: rtl/dcr_pkg.sv
package dcr_pkg;
  localparam int unsigned WORD_W  = 32;
  localparam int unsigned NUM_REG = 4;
  localparam int unsigned SEL_W   = $clog2(NUM_REG);
  localparam int unsigned NUM_AUX = NUM_REG - 1;

  typedef logic [WORD_W-1:0] word_t;

  localparam word_t CTRL_VERSION = 32'hA000_0000;
  localparam word_t CTRL_PROTECT = 32'hFE00_0007;

  localparam int unsigned BIT_PEND   = 0;
  localparam int unsigned BIT_IEN    = 4;
  localparam int unsigned BIT_DRAIN  = 6;
  localparam int unsigned BIT_RESET  = 7;
  localparam int unsigned BIT_CHEN   = 9;
  localparam int unsigned BIT_LOADED = 26;

  // Apply the drain/zero command rules to a raw control write value.
  function automatic word_t cmd_fixup(input word_t raw);
    word_t v;
    v = raw;
    if (raw[BIT_RESET]) begin
      v = raw;
    end else if (raw[BIT_DRAIN]) begin
      v[BIT_DRAIN] = 1'b0;
    end else if (raw == '0) begin
      v[BIT_DRAIN] = 1'b1;
    end
    return v;
  endfunction

  // Merge a fixed-up write into the old control word.
  function automatic word_t ctrl_merge(input word_t old_w, input word_t raw);
    word_t v;
    v = cmd_fixup(raw);
    return (old_w & CTRL_PROTECT) | (v & ~CTRL_PROTECT) | CTRL_VERSION;
  endfunction
endpackage

// File: rtl/dcr_bus_decode.sv
module dcr_bus_decode
  import dcr_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  output logic [NUM_REG-1:0] wr_strobe,
  output logic              rd_req,
  output logic [SEL_W-1:0]  rd_sel
);
  logic [SEL_W-1:0] sel;
  logic             unused_addr_bits;

  assign sel = bus_addr[2 +: SEL_W];
  assign unused_addr_bits = ^{bus_addr[ADDR_W-1:2+SEL_W], bus_addr[1:0]};

  for (genvar g = 0; g < NUM_REG; g++) begin : g_wstb
    assign wr_strobe[g] = bus_valid && bus_write && (sel == SEL_W'(g));
  end

  assign rd_req = bus_valid && !bus_write;
  assign rd_sel = sel;
endmodule

// File: rtl/dcr_ctrl_word.sv
module dcr_ctrl_word
  import dcr_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  ctrl_wr,
  input  logic  addr_wr,
  input  word_t wdata,
  input  logic  irq_req,
  output word_t ctrl_q,
  output logic  irq_out,
  output logic  rst_pulse,
  output logic  chan_en
);
  word_t ctrl_d;

  always_comb begin
    ctrl_d = ctrl_q;
    if (ctrl_wr) begin
      ctrl_d = ctrl_merge(ctrl_q, wdata);
    end
    if (addr_wr) begin
      ctrl_d[BIT_LOADED] = 1'b1;
    end
    ctrl_d[BIT_PEND] = irq_req;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q    <= CTRL_VERSION;
      rst_pulse <= 1'b0;
    end else begin
      ctrl_q    <= ctrl_d;
      rst_pulse <= ctrl_wr && wdata[BIT_RESET];
    end
  end

  assign irq_out = ctrl_q[BIT_PEND] && ctrl_q[BIT_IEN];
  assign chan_en = ctrl_q[BIT_CHEN];
endmodule

// File: rtl/dcr_aux_regs.sv
module dcr_aux_regs
  import dcr_pkg::*;
#(
  parameter int unsigned N = NUM_AUX
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [N-1:0]          wr_strobe,
  input  word_t                 wdata,
  output logic [N-1:0][WORD_W-1:0] regs_q
);
  for (genvar g = 0; g < N; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        regs_q[g] <= '0;
      end else if (wr_strobe[g]) begin
        regs_q[g] <= wdata;
      end
    end
  end
endmodule

// File: rtl/dcr_rd_port.sv
module dcr_rd_port
  import dcr_pkg::*;
(
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        rd_req,
  input  logic [SEL_W-1:0]            rd_sel,
  input  logic [NUM_REG-1:0][WORD_W-1:0] regs,
  output word_t                       rdata,
  output logic                        rvalid
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= rd_req;
      if (rd_req) begin
        rdata <= regs[rd_sel];
      end
    end
  end
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dcr_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              bus_rvalid,
  input  logic              periph_irq_req,
  output logic              irq_out,
  output logic              periph_rst_pulse,
  output logic              periph_dma_en
);
  logic [NUM_REG-1:0]             wr_strobe;
  logic                           rd_req;
  logic [SEL_W-1:0]               rd_sel;
  logic                           ctrl_wr;
  logic                           addr_wr;
  word_t                          ctrl_q;
  logic [NUM_AUX-1:0][WORD_W-1:0] aux_q;
  logic [NUM_REG-1:0][WORD_W-1:0] all_regs;

  dcr_bus_decode #(.ADDR_W(ADDR_W)) u_dec (
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .wr_strobe (wr_strobe),
    .rd_req    (rd_req),
    .rd_sel    (rd_sel)
  );

  assign ctrl_wr = wr_strobe[0];
  assign addr_wr = wr_strobe[1];

  dcr_ctrl_word u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctrl_wr   (ctrl_wr),
    .addr_wr   (addr_wr),
    .wdata     (bus_wdata),
    .irq_req   (periph_irq_req),
    .ctrl_q    (ctrl_q),
    .irq_out   (irq_out),
    .rst_pulse (periph_rst_pulse),
    .chan_en   (periph_dma_en)
  );

  dcr_aux_regs #(.N(NUM_AUX)) u_aux (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_strobe (wr_strobe[NUM_REG-1:1]),
    .wdata     (bus_wdata),
    .regs_q    (aux_q)
  );

  assign all_regs = {aux_q, ctrl_q};

  dcr_rd_port u_rd (
    .clk    (clk),
    .rst_n  (rst_n),
    .rd_req (rd_req),
    .rd_sel (rd_sel),
    .regs   (all_regs),
    .rdata  (bus_rdata),
    .rvalid (bus_rvalid)
  );
endmodule

// File: rtl/dma_chan_regs_chk.sv
module dma_chan_regs_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_valid,
  input logic        bus_write,
  input logic        bus_rvalid,
  input logic        ctrl_wr,
  input logic        addr_wr,
  input logic        wr_rst_bit,
  input logic        wr_drain_bit,
  input logic [31:0] ctrl_q,
  input logic        periph_irq_req,
  input logic        irq_out,
  input logic        periph_rst_pulse,
  input logic        periph_dma_en
);
  AST_RVALID_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rvalid |-> $past(bus_valid && !bus_write)); // R2
  AST_IRQ_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> $past(periph_irq_req)); // R3
  AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && $past(1'b1)) |=> (irq_out -> ctrl_q[4])); // R4
  AST_RST_PULSE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    periph_rst_pulse |-> $past(ctrl_wr && wr_rst_bit)); // R6
  AST_DRAIN_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && !wr_rst_bit && wr_drain_bit) |=> !ctrl_q[6]); // R7
  AST_DMA_EN_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(periph_dma_en) |-> $past(ctrl_wr)); // R8
  AST_VERSION_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[31:27] == 5'b10100) && (ctrl_q[25] == 1'b0) && (ctrl_q[2:1] == 2'b00)); // R9
  AST_LOADED_SET: assert property (@(posedge clk) disable iff (!rst_n)
    addr_wr |=> ctrl_q[26]); // R10
  AST_LOADED_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q[26] |=> ctrl_q[26]); // R10
endmodule

bind dma_chan_regs dma_chan_regs_chk u_chk (
  .clk              (clk),
  .rst_n            (rst_n),
  .bus_valid        (bus_valid),
  .bus_write        (bus_write),
  .bus_rvalid       (bus_rvalid),
  .ctrl_wr          (ctrl_wr),
  .addr_wr          (addr_wr),
  .wr_rst_bit       (bus_wdata[7]),
  .wr_drain_bit     (bus_wdata[6]),
  .ctrl_q           (ctrl_q),
  .periph_irq_req   (periph_irq_req),
  .irq_out          (irq_out),
  .periph_rst_pulse (periph_rst_pulse),
  .periph_dma_en    (periph_dma_en)
);

// File: tb/dma_chan_regs_bench.sv
`timescale 1ns/1ps
module dma_chan_regs_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0;
  logic        bus_write = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic        periph_irq_req = 1'b0;
  logic        irq_out;
  logic        periph_rst_pulse;
  logic        periph_dma_en;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  always #5 clk = ~clk;

  dma_chan_regs u_dma_chan_regs (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .periph_irq_req(periph_irq_req), .irq_out(irq_out),
    .periph_rst_pulse(periph_rst_pulse), .periph_dma_en(periph_dma_en)
  );

  // Behavioural reference model
  logic [31:0] m_reg [4];
  logic        m_pulse, m_rvalid;
  logic [31:0] m_rdata;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_reg[0] = 32'hA000_0000;
      m_reg[1] = 0; m_reg[2] = 0; m_reg[3] = 0;
      m_pulse = 0; m_rvalid = 0; m_rdata = 0;
    end else begin
      int idx;
      logic [31:0] v;
      idx = int'(bus_addr[3:2]);
      m_rvalid = bus_valid && !bus_write;
      if (m_rvalid) m_rdata = m_reg[idx];
      m_pulse = 0;
      if (bus_valid && bus_write) begin
        v = bus_wdata;
        if (idx == 0) begin
          if (v[7]) m_pulse = 1;
          else if (v[6]) v[6] = 1'b0;
          else if (v == 0) v = 32'h40;
          m_reg[0] = (m_reg[0] & 32'hFE00_0007) | (v & 32'h01FF_FFF8) | 32'hA000_0000;
        end else begin
          if (idx == 1) m_reg[0][26] = 1'b1;
          m_reg[idx] = v;
        end
      end
      m_reg[0][0] = periph_irq_req;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Compare against the model on every cycle, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      check("R4 irq_out", 32'(irq_out), 32'(m_reg[0][0] & m_reg[0][4]));
      check("R8 dma_en", 32'(periph_dma_en), 32'(m_reg[0][9]));
      check("R6 rst_pulse", 32'(periph_rst_pulse), 32'(m_pulse));
      check("R2 rvalid", 32'(bus_rvalid), 32'(m_rvalid));
      if (m_rvalid) check("R2 rdata", bus_rdata, m_rdata);
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_valid = 1; bus_write = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); @(negedge clk);
    bus_valid = 0; bus_write = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_valid = 1; bus_write = 0; bus_addr = a;
    @(posedge clk); @(negedge clk);
    bus_valid = 0;
    d = bus_rdata;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    @(negedge clk); @(negedge clk);
    check("R1 irq_out reset", 32'(irq_out), 0);
    check("R1 dma_en reset", 32'(periph_dma_en), 0);
    rst_n = 1;
    @(negedge clk);
    rd(8'h00, d); check("R1 reg0 reset", d, 32'hA000_0000);
    rd(8'h04, d); check("R1 reg1 reset", d, 0);
    rd(8'h0C, d); check("R1 reg3 reset", d, 0);
    // aux registers and aliasing
    wr(8'h08, 32'hDEAD_BEEF);
    wr(8'h0C, 32'h1234_5678);
    rd(8'h08, d); check("R10 reg2", d, 32'hDEAD_BEEF);
    rd(8'hFC, d); check("R2 alias reg3", d, 32'h1234_5678);
    rd(8'h49, d); check("R2 alias reg2", d, 32'hDEAD_BEEF);
    // drain / zero rules
    wr(8'h00, 32'h0);
    rd(8'h00, d); check("R7 zero write", d, 32'hA000_0040);
    wr(8'h00, 32'h40);
    rd(8'h00, d); check("R7 drain cleared", d, 32'hA000_0000);
    bus_valid = 1; bus_write = 1; bus_addr = 8'h00; bus_wdata = 32'hC0;
    @(posedge clk); @(negedge clk);
    bus_valid = 0; bus_write = 0;
    check("R6 pulse high", 32'(periph_rst_pulse), 1);
    @(negedge clk);
    check("R6 pulse one cycle", 32'(periph_rst_pulse), 0);
    rd(8'h00, d); check("R6 R7 reset keeps drain", d, 32'hA000_00C0);
    wr(8'h00, 32'hFFFF_FFFF);
    rd(8'h00, d); check("R5 R9 protect mask", d, 32'hA1FF_FFF8);
    check("R8 dma_en set", 32'(periph_dma_en), 1);
    // interrupt
    wr(8'h00, 32'h10);
    check("R8 dma_en cleared", 32'(periph_dma_en), 0);
    periph_irq_req = 1;
    @(negedge clk);
    check("R3 R4 irq raised", 32'(irq_out), 1);
    wr(8'h00, 32'h200);
    check("R4 irq dropped by enable clear", 32'(irq_out), 0);
    rd(8'h00, d); check("R3 pending kept", d, 32'hA000_0201);
    wr(8'h00, 32'h210);
    check("R4 irq raised by enable", 32'(irq_out), 1);
    periph_irq_req = 0;
    @(negedge clk);
    check("R3 irq follows req low", 32'(irq_out), 0);
    // loaded bit
    wr(8'h04, 32'h0000_1000);
    rd(8'h00, d); check("R10 loaded set", d & 32'h0400_0000, 32'h0400_0000);
    rd(8'h04, d); check("R10 addr stored", d, 32'h0000_1000);
    wr(8'h00, 32'h0);
    rd(8'h00, d); check("R9 R10 loaded sticky", d, 32'hA400_0040);
    repeat (3) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule